// File: doc/BRIEF.md
# Multi-Kernel Workgroup Dispatch Scheduler

This block keeps an ordered set of pending kernels and hands their workgroups, one at a time, to an external compute-unit allocator. Each pending kernel has a small record: its ID, the number of workgroups not yet granted, whether it must wait for a cache invalidate before it starts, and whether its first workgroup has gone out yet. A separate table of invalidate counters, one per kernel ID, is stepped up and down by the memory side. A kernel that needs the acquire step stays gated while its counter is non-zero.

The scheduler looks at the kernel at the head of the queue. If that kernel is gated, or the allocator refuses its workgroup, the kernel moves to the back of the queue and a per-pass failure count goes up by one. The walk continues while the queue holds more kernels than that count. This lets a kernel with smaller workgroups, or with its invalidate already done, overtake a stalled one, and it guarantees that a pass ends. A new pass starts, and the count clears, when a launch is accepted, when an invalidate counter drops to zero, or when the allocator reports freed capacity.

Launches use a valid/ready handshake. `lq_ready_o` is low while the queue is full and during the one cycle in which a blocked kernel is moved to the tail. A launch transfers on a rising edge where `lq_valid_i` and `lq_ready_o` are both high. Workgroup requests are held until the allocator answers with either a grant or a refusal.

Top module: `wg_dispatch_sched`

## Requirements
- R1: A launch is accepted only when `lq_valid_i` and `lq_ready_o` are both high. `lq_ready_o` is low whenever DEPTH kernels are pending, and a launch offered while it is low is never dispatched.
- R2: A kernel launched with `lq_acq_i`=1 issues no workgroup request while the invalidate counter of its ID is non-zero. A kernel queued behind it is served first.
- R3: A kernel launched with `lq_acq_i`=0 is dispatched regardless of the invalidate counter of its ID.
- R4: At most one workgroup request is outstanding. `wg_req_o` and `wg_req_id_o` stay unchanged until `wg_ack_i` or `wg_nack_i` answers the request.
- R5: A refused kernel moves to the tail of the queue. When it is dispatched later, it resumes with its remaining workgroups, so the total number of grants equals its workgroup total.
- R6: `kern_launched_o` pulses exactly once per kernel, with `kern_launched_id_o` naming it, one cycle after its first granted workgroup.
- R7: A kernel leaves the queue once its last workgroup is granted, and it issues no further requests.
- R8: A pass examines the head only while the pending count exceeds the failures recorded in that pass. When every pending kernel has failed once, requests stop until the next trigger: an accepted launch, an invalidate counter reaching zero, or `slot_freed_i`.
- R9: `wait_cycles_o` rises by exactly one in every cycle in which at least one kernel is pending, and it holds otherwise.
- R10: An invalidate update changes the counter of `inv_id_i` by +1 when `inv_up_i`=1 and by -1 when `inv_up_i`=0. A gated kernel is released only when the count reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lq_valid_i | input | 1 | Launch offer valid |
| lq_ready_o | output | 1 | Launch can be accepted |
| lq_id_i | input | ID_W | Kernel ID of the launch |
| lq_wg_i | input | WG_W | Workgroup total (non-zero) |
| lq_acq_i | input | 1 | 1: wait for invalidate counter to reach zero |
| inv_valid_i | input | 1 | Invalidate counter update strobe |
| inv_id_i | input | ID_W | Kernel ID whose counter is updated |
| inv_up_i | input | 1 | 1: +1, 0: -1 |
| slot_freed_i | input | 1 | Allocator capacity freed; restarts the walk |
| wg_req_o | output | 1 | Workgroup request outstanding |
| wg_req_id_o | output | ID_W | Kernel ID of the requested workgroup |
| wg_ack_i | input | 1 | Request granted |
| wg_nack_i | input | 1 | Request refused |
| kern_launched_o | output | 1 | First workgroup of a kernel was granted |
| kern_launched_id_o | output | ID_W | ID for kern_launched_o |
| wait_cycles_o | output | STAT_W | Count of cycles with pending kernels |

## Verification
The embedded properties assume that the allocator never grants and refuses in the same cycle, and that it answers only while a request is up. They also assume that invalidate updates never step a counter below zero or past its maximum. The bench's allocator model answers only on a negative edge where it sees `wg_req_o` high. Every invalidate increment in a scenario is paired with a later decrement on the same ID. Kernel IDs are never reused while a kernel is still pending, and every workgroup total is at least one.

// File: rtl/wds_pkg.sv
package wds_pkg;
  typedef enum logic [1:0] {
    WS_EXAM = 2'd0,
    WS_WAIT = 2'd1,
    WS_ROT  = 2'd2
  } wds_state_e;

  localparam logic INV_STEP_UP = 1'b1;
endpackage

// File: rtl/wds_queue.sv
module wds_queue #(
  parameter int DEPTH = 4,
  parameter int ID_W  = 4,
  parameter int WG_W  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [ID_W-1:0]  push_id_i,
  input  logic [WG_W-1:0]  push_wg_i,
  input  logic             push_acq_i,
  input  logic             pop_i,
  input  logic             rot_i,
  input  logic             upd_i,
  input  logic [WG_W-1:0]  upd_wg_i,
  output logic [ID_W-1:0]  head_id_o,
  output logic [WG_W-1:0]  head_wg_o,
  output logic             head_acq_o,
  output logic             head_lch_o,
  output logic [CNT_W-1:0] count_o
);
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  logic [ID_W-1:0] id_v  [DEPTH];
  logic [WG_W-1:0] wg_v  [DEPTH];
  logic            acq_v [DEPTH];
  logic            lch_v [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_id_o  = id_v[head_q];
  assign head_wg_o  = wg_v[head_q];
  assign head_acq_o = acq_v[head_q];
  assign head_lch_o = lch_v[head_q];
  assign count_o    = count_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [ID_W-1:0] id_r;
    logic [WG_W-1:0] wg_r;
    logic            acq_r, lch_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        id_r <= '0; wg_r <= '0; acq_r <= 1'b0; lch_r <= 1'b0;
      end else if (push_i && tail_q == PTR_W'(g)) begin
        id_r <= push_id_i; wg_r <= push_wg_i; acq_r <= push_acq_i; lch_r <= 1'b0;
      end else if (rot_i && tail_q == PTR_W'(g)) begin
        id_r <= head_id_o; wg_r <= head_wg_o; acq_r <= head_acq_o; lch_r <= head_lch_o;
      end else if (upd_i && head_q == PTR_W'(g)) begin
        wg_r  <= upd_wg_i;
        lch_r <= 1'b1;
      end
    end
    assign id_v[g]  = id_r;
    assign wg_v[g]  = wg_r;
    assign acq_v[g] = acq_r;
    assign lch_v[g] = lch_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i || rot_i) tail_q <= ptr_inc(tail_q);
      if (pop_i  || rot_i) head_q <= ptr_inc(head_q);
      count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  // R1: never written past capacity
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (count_q < CNT_W'(DEPTH)));
  // R5: rotation needs an entry and excludes a launch write
  a_r5_rot_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rot_i |-> (count_q != '0) && !push_i && !pop_i);
  // R7: removal only from a non-empty queue
  a_r7_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (count_q != '0));
endmodule

// File: rtl/wds_inv_track.sv
module wds_inv_track
  import wds_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int INV_W = 4,
  localparam int N_ID = 1 << ID_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_v_i,
  input  logic [ID_W-1:0] upd_id_i,
  input  logic            upd_up_i,
  output logic [N_ID-1:0] busy_o,
  output logic            zero_hit_o
);
  logic [INV_W-1:0] cnt_v [N_ID];

  for (genvar g = 0; g < N_ID; g++) begin : g_ctr
    logic [INV_W-1:0] cnt_r;
    logic             hit;
    assign hit = upd_v_i && (upd_id_i == ID_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)                         cnt_r <= '0;
      else if (hit && upd_up_i == INV_STEP_UP) cnt_r <= cnt_r + 1'b1;
      else if (hit)                       cnt_r <= cnt_r - 1'b1;
    end
    assign cnt_v[g]  = cnt_r;
    assign busy_o[g] = (cnt_r != '0);
  end

  assign zero_hit_o = upd_v_i && (upd_up_i != INV_STEP_UP) &&
                      (cnt_v[upd_id_i] == INV_W'(1));

  // R10: input contract, counter never stepped below zero
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_v_i && upd_up_i != INV_STEP_UP) |-> busy_o[upd_id_i]);
  // R10: input contract, counter never wraps upward
  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_v_i && upd_up_i == INV_STEP_UP) |-> (cnt_v[upd_id_i] != '1));
endmodule

// File: rtl/wds_walker.sv
module wds_walker
  import wds_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int ID_W  = 4,
  parameter int WG_W  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic [ID_W-1:0]  head_id_i,
  input  logic [WG_W-1:0]  head_wg_i,
  input  logic             head_acq_i,
  input  logic             head_lch_i,
  input  logic             head_busy_i,
  input  logic             trig_i,
  input  logic             wg_ack_i,
  input  logic             wg_nack_i,
  output logic             wg_req_o,
  output logic [ID_W-1:0]  wg_req_id_o,
  output logic             rot_o,
  output logic             pop_o,
  output logic             upd_o,
  output logic [WG_W-1:0]  upd_wg_o,
  output logic             lch_o,
  output logic [ID_W-1:0]  lch_id_o
);
  wds_state_e       st_q, st_d;
  logic [CNT_W-1:0] fail_q;
  logic             lch_q;
  logic [ID_W-1:0]  lch_id_q;
  logic             walking;

  assign walking = (count_i > fail_q);

  always_comb begin
    st_d     = st_q;
    wg_req_o = 1'b0;
    rot_o    = 1'b0;
    pop_o    = 1'b0;
    upd_o    = 1'b0;
    upd_wg_o = head_wg_i - 1'b1;
    unique case (st_q)
      WS_EXAM: begin
        if (walking) st_d = (head_acq_i && head_busy_i) ? WS_ROT : WS_WAIT;
      end
      WS_WAIT: begin
        wg_req_o = 1'b1;
        if (wg_ack_i) begin
          upd_o = 1'b1;
          if (head_wg_i == WG_W'(1)) begin
            pop_o = 1'b1;
            st_d  = WS_EXAM;
          end
        end else if (wg_nack_i) begin
          st_d = WS_ROT;
        end
      end
      WS_ROT: begin
        rot_o = 1'b1;
        st_d  = WS_EXAM;
      end
      default: st_d = WS_EXAM;
    endcase
  end

  assign wg_req_id_o = head_id_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= WS_EXAM;
      fail_q   <= '0;
      lch_q    <= 1'b0;
      lch_id_q <= '0;
    end else begin
      st_q <= st_d;
      if (trig_i)     fail_q <= '0;
      else if (rot_o) fail_q <= fail_q + 1'b1;
      lch_q    <= wg_req_o && wg_ack_i && !head_lch_i;
      lch_id_q <= head_id_i;
    end
  end

  assign lch_o    = lch_q;
  assign lch_id_o = lch_id_q;

  // R4: request held until answered
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wg_req_o && !wg_ack_i && !wg_nack_i) |=> (wg_req_o && $stable(wg_req_id_o)));
  // R4: input contract on the response pins
  a_r4_resp_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (wg_ack_i || wg_nack_i) |-> (wg_req_o && !(wg_ack_i && wg_nack_i)));
  // R2: a fresh request never starts for a gated kernel
  a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wg_req_o) |-> !($past(head_acq_i) && $past(head_busy_i)));
  // R6: launch pulse follows a grant
  a_r6_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    lch_o |-> $past(wg_ack_i));
  // R8: failures in a pass never exceed the queue capacity
  always_comb begin
    if (rst_n) a_r8_fail_bound: assert (fail_q <= CNT_W'(DEPTH));
  end
endmodule

// File: rtl/wg_dispatch_sched.sv
module wg_dispatch_sched #(
  parameter int DEPTH  = 4,
  parameter int ID_W   = 4,
  parameter int WG_W   = 8,
  parameter int INV_W  = 4,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lq_valid_i,
  output logic              lq_ready_o,
  input  logic [ID_W-1:0]   lq_id_i,
  input  logic [WG_W-1:0]   lq_wg_i,
  input  logic              lq_acq_i,
  input  logic              inv_valid_i,
  input  logic [ID_W-1:0]   inv_id_i,
  input  logic              inv_up_i,
  input  logic              slot_freed_i,
  output logic              wg_req_o,
  output logic [ID_W-1:0]   wg_req_id_o,
  input  logic              wg_ack_i,
  input  logic              wg_nack_i,
  output logic              kern_launched_o,
  output logic [ID_W-1:0]   kern_launched_id_o,
  output logic [STAT_W-1:0] wait_cycles_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int N_ID  = 1 << ID_W;

  logic [CNT_W-1:0] count;
  logic [ID_W-1:0]  head_id;
  logic [WG_W-1:0]  head_wg, upd_wg;
  logic             head_acq, head_lch;
  logic             push, pop, rot, upd, trig, zero_hit;
  logic [N_ID-1:0]  busy;
  logic [STAT_W-1:0] stat_q;

  assign lq_ready_o = (count < CNT_W'(DEPTH)) && !rot;
  assign push       = lq_valid_i && lq_ready_o;
  assign trig       = push || zero_hit || slot_freed_i;

  wds_queue #(.DEPTH(DEPTH), .ID_W(ID_W), .WG_W(WG_W)) queue_i (
    .clk(clk), .rst_n(rst_n),
    .push_i(push), .push_id_i(lq_id_i), .push_wg_i(lq_wg_i), .push_acq_i(lq_acq_i),
    .pop_i(pop), .rot_i(rot), .upd_i(upd), .upd_wg_i(upd_wg),
    .head_id_o(head_id), .head_wg_o(head_wg), .head_acq_o(head_acq),
    .head_lch_o(head_lch), .count_o(count)
  );

  wds_inv_track #(.ID_W(ID_W), .INV_W(INV_W)) inv_i (
    .clk(clk), .rst_n(rst_n),
    .upd_v_i(inv_valid_i), .upd_id_i(inv_id_i), .upd_up_i(inv_up_i),
    .busy_o(busy), .zero_hit_o(zero_hit)
  );

  wds_walker #(.DEPTH(DEPTH), .ID_W(ID_W), .WG_W(WG_W)) walk_i (
    .clk(clk), .rst_n(rst_n),
    .count_i(count), .head_id_i(head_id), .head_wg_i(head_wg),
    .head_acq_i(head_acq), .head_lch_i(head_lch), .head_busy_i(busy[head_id]),
    .trig_i(trig), .wg_ack_i(wg_ack_i), .wg_nack_i(wg_nack_i),
    .wg_req_o(wg_req_o), .wg_req_id_o(wg_req_id_o),
    .rot_o(rot), .pop_o(pop), .upd_o(upd), .upd_wg_o(upd_wg),
    .lch_o(kern_launched_o), .lch_id_o(kern_launched_id_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)             stat_q <= '0;
    else if (count != '0)   stat_q <= stat_q + 1'b1;
  end
  assign wait_cycles_o = stat_q;

  // R9: statistic steps by one per pending cycle
  a_r9_stat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) |=> (wait_cycles_o == $past(wait_cycles_o) + 1'b1));
  a_r9_stat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |=> $stable(wait_cycles_o));
  // R1: ready never offered at capacity
  a_r1_ready_cap: assert property (@(posedge clk) disable iff (!rst_n)
    lq_ready_o |-> (count != CNT_W'(DEPTH)));
  // R1: input contract, a launch carries work
  a_r1_wg_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lq_valid_i |-> (lq_wg_i != '0));
endmodule

// File: tb/wg_dispatch_sched_tb_top.sv
`timescale 1ns/1ps
module wg_dispatch_sched_tb_top;
  localparam int ID_W = 4;
  localparam int WG_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lq_valid = 1'b0, lq_acq = 1'b0;
  logic [ID_W-1:0] lq_id = '0;
  logic [WG_W-1:0] lq_wg = 8'd1;
  logic lq_ready;
  logic inv_v = 1'b0, inv_up = 1'b0;
  logic [ID_W-1:0] inv_id = '0;
  logic slot_freed = 1'b0;
  logic wg_req, wg_ack = 1'b0, wg_nack = 1'b0;
  logic [ID_W-1:0] wg_req_id;
  logic kl;
  logic [ID_W-1:0] kl_id;
  logic [31:0] stat;

  int n_chk = 0, n_err = 0;
  int grants[16], nacks[16], lch_cnt[16];
  int glog[64];
  int gidx = 0;
  int req_seen = 0;
  bit refuse_all = 1'b0;
  bit [15:0] refuse_mask = '0;
  int budget = 1000;

  always #2.5 clk = ~clk;

  wg_dispatch_sched dut_i (
    .clk(clk), .rst_n(rst_n),
    .lq_valid_i(lq_valid), .lq_ready_o(lq_ready), .lq_id_i(lq_id), .lq_wg_i(lq_wg),
    .lq_acq_i(lq_acq), .inv_valid_i(inv_v), .inv_id_i(inv_id), .inv_up_i(inv_up),
    .slot_freed_i(slot_freed), .wg_req_o(wg_req), .wg_req_id_o(wg_req_id),
    .wg_ack_i(wg_ack), .wg_nack_i(wg_nack), .kern_launched_o(kl),
    .kern_launched_id_o(kl_id), .wait_cycles_o(stat)
  );

  // allocator model: samples outputs, then answers the live request
  always @(negedge clk) begin
    if (rst_n && kl) lch_cnt[kl_id] = lch_cnt[kl_id] + 1;
    if (rst_n && wg_req) begin
      req_seen = req_seen + 1;
      if (!refuse_all && !refuse_mask[wg_req_id] && budget > 0) begin
        wg_ack = 1'b1; wg_nack = 1'b0;
        grants[wg_req_id] = grants[wg_req_id] + 1;
        budget = budget - 1;
        if (gidx < 64) glog[gidx] = int'(wg_req_id);
        gidx = gidx + 1;
      end else begin
        wg_ack = 1'b0; wg_nack = 1'b1;
        nacks[wg_req_id] = nacks[wg_req_id] + 1;
      end
    end else begin
      wg_ack = 1'b0; wg_nack = 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic launch(input int id, input int n, input bit acq);
    lq_id = ID_W'(id); lq_wg = WG_W'(n); lq_acq = acq;
    while (!lq_ready) @(negedge clk);
    lq_valid = 1'b1;
    @(negedge clk);
    lq_valid = 1'b0;
  endtask

  task automatic inv_step(input int id, input bit up);
    inv_id = ID_W'(id); inv_up = up; inv_v = 1'b1;
    @(negedge clk);
    inv_v = 1'b0;
  endtask

  task automatic free_pulse();
    slot_freed = 1'b1;
    @(negedge clk);
    slot_freed = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset ready", int'(lq_ready), 1);
    chk("R4 reset req", int'(wg_req), 0);
    chk("R6 reset launched", int'(kl), 0);
    chk("R9 reset stat", int'(stat), 0);
  endtask

  task automatic t_basic();
    int s0;
    launch(1, 3, 1'b0);
    cyc(20);
    chk("R5 basic grants", grants[1], 3);
    chk("R6 basic launched once", lch_cnt[1], 1);
    chk("R7 basic no extra", nacks[1], 0);
    s0 = int'(stat);
    cyc(5);
    chk("R9 stat holds when empty", int'(stat), s0);
  endtask

  task automatic t_inv_gate();
    int g0, r0;
    inv_step(2, 1'b1);
    inv_step(2, 1'b1);
    r0 = req_seen;
    launch(2, 2, 1'b1);
    cyc(10);
    chk("R8 gated alone issues no request", req_seen - r0, 0);
    g0 = gidx;
    launch(3, 2, 1'b0);
    cyc(15);
    chk("R2 later kernel served", grants[3], 2);
    chk("R2 gated kernel held", grants[2], 0);
    chk("R2 overtake order", glog[g0], 3);
    inv_step(2, 1'b0);
    cyc(10);
    chk("R10 one decrement keeps gate", grants[2], 0);
    inv_step(2, 1'b0);
    cyc(15);
    chk("R10 release at zero", grants[2], 2);
    chk("R6 gated kernel launched once", lch_cnt[2], 1);
  endtask

  task automatic t_no_acq();
    inv_step(4, 1'b1);
    launch(4, 2, 1'b0);
    cyc(15);
    chk("R3 counter ignored without acquire", grants[4], 2);
    inv_step(4, 1'b0);
  endtask

  task automatic t_refuse();
    int r0, s0;
    refuse_all = 1'b1;
    r0 = req_seen;
    launch(5, 4, 1'b0);
    cyc(12);
    chk("R8 single refused attempt", req_seen - r0, 1);
    chk("R6 no launch before grant", lch_cnt[5], 0);
    s0 = int'(stat);
    cyc(10);
    chk("R9 stat counts pending cycles", int'(stat) - s0, 10);
    refuse_all = 1'b0;
    budget = 2;
    free_pulse();
    cyc(15);
    chk("R5 partial dispatch", grants[5], 2);
    chk("R5 refused twice", nacks[5], 2);
    budget = 1000;
    free_pulse();
    cyc(15);
    chk("R5 resume remaining", grants[5], 4);
    chk("R6 launched once after resume", lch_cnt[5], 1);
  endtask

  task automatic t_overtake();
    refuse_mask[6] = 1'b1;
    launch(6, 2, 1'b0);
    launch(7, 2, 1'b0);
    cyc(15);
    chk("R5 refused kernel overtaken", grants[7], 2);
    chk("R5 refused kernel waits", grants[6], 0);
    refuse_mask[6] = 1'b0;
    free_pulse();
    cyc(15);
    chk("R7 all dispatched", grants[6], 2);
  endtask

  task automatic t_full();
    int acc;
    int r0;
    refuse_all = 1'b1;
    for (int k = 8; k < 12; k++) launch(k, 1, 1'b0);
    cyc(10);
    chk("R1 ready low when full", int'(lq_ready), 0);
    lq_id = 4'd12; lq_wg = 8'd1; lq_acq = 1'b0;
    acc = 0;
    lq_valid = 1'b1;
    for (int k = 0; k < 6; k++) begin
      if (lq_ready) acc++;
      @(negedge clk);
    end
    lq_valid = 1'b0;
    chk("R1 offer refused while full", acc, 0);
    refuse_all = 1'b0;
    free_pulse();
    cyc(30);
    chk("R7 drained 8", grants[8], 1);
    chk("R7 drained 11", grants[11], 1);
    chk("R1 blocked launch never dispatched", grants[12], 0);
    chk("R7 ready back", int'(lq_ready), 1);
    r0 = req_seen;
    cyc(10);
    chk("R7 no requests after drain", req_seen - r0, 0);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) begin grants[k] = 0; nacks[k] = 0; lch_cnt[k] = 0; end
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_basic();
    t_inv_gate();
    t_no_acq();
    t_refuse();
    t_overtake();
    t_full();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule